// File: doc/BRIEF.md
# CAN Time-Quantum Clock Prescaler

This block turns one free-running oscillator clock into the two clock enables that a CAN controller's bit-timing logic runs on. It does not create any derived clocks. The oscillator feeds a power-of-two divider whose ratio is set by a 3-bit code. Each terminal count of that divider gives a one-cycle system clock enable. The system enable then passes through a fixed halving stage and a programmable divide-by-(P+1) stage, and the result is the time-quantum enable. One quantum therefore spans 2·(P+1)·N oscillator cycles, where N is the first-stage ratio.

Software-facing logic elsewhere supplies the divider code, the 4-bit prescale value P and a module enable. Bit segmentation logic counts quanta on the `tq_ce` pulses. A new code or a new P is applied only at the next terminal count of the stage it affects, so a period that is already running is never cut short or stretched. Dropping the enable clears every counter. The first quantum after re-enabling then has its full length.

Top module: `cqp_tq_prescaler`

## Requirements
- R1: While `rst` is high (sampled synchronously), `sys_ce` and `tq_ce` are low and all counters clear, whatever the other inputs are.
- R2: Divider codes 0, 1, 2, 3 and 4 give a `sys_ce` period of 1, 2, 4, 8 and 16 oscillator cycles. The first pulse comes in the N-th enabled cycle, and for N > 1 each pulse is one cycle wide.
- R3: Codes 5, 6 and 7 are reserved and behave exactly like code 0 (divide-by-1).
- R4: With divide-by-1 in force, `sys_ce` is high in every enabled cycle.
- R5: `tq_ce` pulses once every 2·(P+1)·N oscillator cycles. The first pulse comes in cycle 2·(P+1)·N counted from the first enabled cycle.
- R6: `tq_ce` is only ever high in a cycle where `sys_ce` is also high.
- R7: `tq_ce` is never high in two consecutive cycles, including at the fastest setting (code 0, P = 0, period 2).
- R8: While `en` is low, no enable pulses are produced and all counters are held at zero. After `en` rises again, timing restarts exactly as after reset.
- R9: A change of the divider code while enabled takes effect only after the next `sys_ce` pulse. The pulse at the end of the running period still arrives at the old spacing.
- R10: A change of P while enabled takes effect only after the next `tq_ce` pulse.
- R11: The full P range 0..15 is supported. Code 4 with P = 15 gives a 512-cycle quantum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low holds all counters at zero |
| div_sel | input | 3 | First-stage divider code (0..4 = /1../16, 5..7 = /1) |
| brp | input | 4 | Prescale value P; last stage divides by P+1 |
| sys_ce | output | 1 | CAN system clock enable |
| tq_ce | output | 1 | Time-quantum enable, one oscillator cycle wide |

## Verification
The bench compares the exact cycle of every `sys_ce` and `tq_ce` pulse against a precomputed schedule, for all eight divider codes, at both ends of the P range and at the fastest setting. A design that let reserved codes index past the divider table would produce a wrong period. A halving stage that leaked every system pulse would halve the quantum length. Two cases change the code or P in the middle of a period; a design that applied the new setting at once would produce an early pulse or miss a terminal count, which shows as an unexpected or missing pulse. Dropping the enable part-way through a period, and checking that the first quantum after re-enabling has full length, catches counters that keep their stale values.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    // Default widths shared by every stage
    localparam int unsigned SEL_W_D   = 3;
    localparam int unsigned BRP_W_D   = 4;
    localparam int unsigned LOG_MAX_D = 4;

    // Divider select codes; anything above the largest legal code is reserved
    typedef enum logic [SEL_W_D-1:0] {
        DIV_BY_1  = 3'd0,
        DIV_BY_2  = 3'd1,
        DIV_BY_4  = 3'd2,
        DIV_BY_8  = 3'd3,
        DIV_BY_16 = 3'd4
    } div_code_e;

    // Map a select code to a power-of-two exponent; reserved codes fall back to /1
    function automatic int unsigned div_log(input int unsigned code,
                                            input int unsigned max_log);
        return (code <= max_log) ? code : 0;
    endfunction

    // Terminal count of a 2**exp divider
    function automatic int unsigned pow2_last(input int unsigned exp_v);
        return (1 << exp_v) - 1;
    endfunction

endpackage

// File: rtl/cqp_pow2_div.sv
module cqp_pow2_div
    import cqp_pkg::*;
#(
    parameter int unsigned SEL_W   = SEL_W_D,
    parameter int unsigned LOG_MAX = LOG_MAX_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             ce
);
    localparam int unsigned LOG_W = $clog2(LOG_MAX + 1);
    localparam int unsigned CNT_W = (LOG_MAX > 0) ? LOG_MAX : 1;

    generate
        if (LOG_MAX == 0) begin : g_bypass
            assign ce = run;
        end else begin : g_count
            logic [LOG_W-1:0] shift_q;
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W-1:0] last;
            logic [LOG_W-1:0] shift_nxt;

            always_comb begin
                last      = CNT_W'(pow2_last(int'(shift_q)));
                shift_nxt = LOG_W'(div_log(int'(sel), LOG_MAX));
                ce        = run && (cnt_q == last);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    shift_q <= '0;
                    cnt_q   <= '0;
                end else if (!run) begin
                    shift_q <= shift_nxt;
                    cnt_q   <= '0;
                end else if (ce) begin
                    shift_q <= shift_nxt;
                    cnt_q   <= '0;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                end
            end

            // R9
            sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (run && !ce) |=> $stable(shift_q));
            // R2
            ce_width_chk: assert property (@(posedge clk) disable iff (rst)
                (ce && shift_q != '0) |=> !ce);
            // R8
            idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
                !run |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/cqp_half_div.sv
module cqp_half_div (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic in_ce,
    output logic out_ce
);
    logic phase_q;

    assign out_ce = in_ce && phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= 1'b0;
        end else if (in_ce) begin
            phase_q <= ~phase_q;
        end
    end

    // R7
    half_gap_chk: assert property (@(posedge clk) disable iff (rst)
        out_ce |=> !out_ce);

endmodule

// File: rtl/cqp_brp_div.sv
module cqp_brp_div
    import cqp_pkg::*;
#(
    parameter int unsigned BRP_W = BRP_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             in_ce,
    input  logic [BRP_W-1:0] brp,
    output logic             out_ce
);
    logic [BRP_W-1:0] lim_q;
    logic [BRP_W-1:0] cnt_q;

    assign out_ce = in_ce && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (!run) begin
            lim_q <= brp;
            cnt_q <= '0;
        end else if (in_ce) begin
            if (out_ce) begin
                lim_q <= brp;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R10
    brp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !out_ce) |=> $stable(lim_q));
    // R7
    tq_gap_chk: assert property (@(posedge clk) disable iff (rst)
        out_ce |=> !out_ce);

endmodule

// File: rtl/cqp_tq_prescaler.sv
module cqp_tq_prescaler
    import cqp_pkg::*;
#(
    parameter int unsigned SEL_W   = SEL_W_D,
    parameter int unsigned BRP_W   = BRP_W_D,
    parameter int unsigned LOG_MAX = LOG_MAX_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [BRP_W-1:0] brp,
    output logic             sys_ce,
    output logic             tq_ce
);
    logic run;
    logic half_ce;

    assign run = en && !rst;

    cqp_pow2_div #(
        .SEL_W   (SEL_W),
        .LOG_MAX (LOG_MAX)
    ) u_pow2 (
        .clk (clk),
        .rst (rst),
        .run (run),
        .sel (div_sel),
        .ce  (sys_ce)
    );

    cqp_half_div u_half (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .in_ce  (sys_ce),
        .out_ce (half_ce)
    );

    cqp_brp_div #(
        .BRP_W (BRP_W)
    ) u_brp (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .in_ce  (half_ce),
        .brp    (brp),
        .out_ce (tq_ce)
    );

    // R6
    tq_in_sys_chk: assert property (@(posedge clk) disable iff (rst)
        tq_ce |-> sys_ce);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sys_ce && !tq_ce));
    // R1
    always_comb begin
        if (rst) reset_quiet_chk: assert (!sys_ce && !tq_ce);
    end

endmodule

// File: tb/test_cqp_tq_prescaler.sv
module test_cqp_tq_prescaler;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [2:0] div_sel = 3'd0;
    logic [3:0] brp = 4'd0;
    logic       sys_ce;
    logic       tq_ce;

    int   ncyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sys_q[$];
    exp_t tq_q[$];

    always #2 clk = ~clk;

    cqp_tq_prescaler i_cqp_tq_prescaler (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div_sel (div_sel),
        .brp     (brp),
        .sys_ce  (sys_ce),
        .tq_ce   (tq_ce)
    );

    // Monitor: compare every sample against the head of each queue
    always @(negedge clk) begin
        if (rst) begin
            n_chk++;
            if (sys_ce || tq_ce) begin
                n_fail++;
                $display("FAIL R1 cycle %0d: sys_ce=%b tq_ce=%b expected 0 0", ncyc, sys_ce, tq_ce);
            end
        end else begin
            if (sys_q.size() > 0 && sys_q[0].at == ncyc) begin
                n_chk++;
                if (!sys_ce) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: sys_ce=0 expected 1", sys_q[0].req, ncyc);
                end
                void'(sys_q.pop_front());
            end else if (sys_ce) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s cycle %0d: sys_ce=1 expected 0",
                         (sys_q.size() > 0) ? sys_q[0].req : "R8", ncyc);
            end
            if (tq_q.size() > 0 && tq_q[0].at == ncyc) begin
                n_chk++;
                if (!tq_ce) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: tq_ce=0 expected 1", tq_q[0].req, ncyc);
                end
                void'(tq_q.pop_front());
            end else if (tq_ce) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s cycle %0d: tq_ce=1 expected 0",
                         (tq_q.size() > 0) ? tq_q[0].req : "R8", ncyc);
            end
        end
        ncyc++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_idx(input int i);
        while (ncyc != i) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push_sys(input int at, input string r);
        exp_t e;
        e.at = at;
        e.req = r;
        sys_q.push_back(e);
    endtask

    task automatic push_tq(input int at, input string r);
        exp_t e;
        e.at = at;
        e.req = r;
        tq_q.push_back(e);
    endtask

    task automatic drain_and_stop();
        while (sys_q.size() != 0 || tq_q.size() != 0) begin
            @(posedge clk);
            #1;
        end
        en = 1'b0;
        wait_cyc(3);
    endtask

    // Driver: start from a cleared state and schedule n quanta
    task automatic run_cfg(input int sel, input int p, input int n,
                           input string rs, input string rt);
        int s;
        int nn;
        int t;
        en      = 1'b0;
        div_sel = sel[2:0];
        brp     = p[3:0];
        wait_cyc(2);
        en = 1'b1;
        s  = ncyc;
        nn = (sel <= 4) ? (1 << sel) : 1;
        t  = 2 * (p + 1) * nn;
        for (int k = nn - 1; k < n * t; k += nn) push_sys(s + k, rs);
        for (int k = t - 1; k < n * t; k += t) push_tq(s + k, rt);
        drain_and_stop();
    endtask

    initial begin
        int s;
        // R1: hold reset with enable high for a few cycles
        wait_cyc(4);
        rst = 1'b0;
        en  = 1'b0;
        wait_cyc(2);

        // R4 and R5: divide-by-1 at several P values
        run_cfg(0, 0, 4, "R4", "R7");
        run_cfg(0, 3, 2, "R4", "R5");
        // R2 and R5: each legal code
        run_cfg(1, 1, 2, "R2", "R5");
        run_cfg(2, 2, 2, "R2", "R5");
        run_cfg(3, 0, 3, "R2", "R5");
        run_cfg(4, 1, 2, "R2", "R5");
        // R3: reserved codes act as divide-by-1
        run_cfg(5, 1, 2, "R3", "R3");
        run_cfg(6, 0, 3, "R3", "R3");
        run_cfg(7, 2, 1, "R3", "R3");
        // R11: longest quantum
        run_cfg(4, 15, 1, "R11", "R11");

        // R9: code change mid-period, /4 -> /2, P = 0
        en = 1'b0; div_sel = 3'd2; brp = 4'd0;
        wait_cyc(2);
        en = 1'b1; s = ncyc;
        push_sys(s + 3, "R9"); push_sys(s + 5, "R9");
        push_sys(s + 7, "R9"); push_sys(s + 9, "R9");
        push_tq(s + 5, "R9");  push_tq(s + 9, "R9");
        wait_idx(s + 1);
        div_sel = 3'd1;
        drain_and_stop();

        // R10: P change mid-quantum, /1, P 1 -> 3
        en = 1'b0; div_sel = 3'd0; brp = 4'd1;
        wait_cyc(2);
        en = 1'b1; s = ncyc;
        for (int k = 0; k < 12; k++) push_sys(s + k, "R10");
        push_tq(s + 3, "R10"); push_tq(s + 11, "R10");
        wait_idx(s + 2);
        brp = 4'd3;
        drain_and_stop();

        // R8: drop enable part-way, stay quiet, then restart fresh
        en = 1'b0; div_sel = 3'd1; brp = 4'd2;
        wait_cyc(2);
        en = 1'b1; s = ncyc;
        push_sys(s + 1, "R8"); push_sys(s + 3, "R8"); push_sys(s + 5, "R8");
        wait_idx(s + 6);
        en = 1'b0;
        wait_cyc(6);
        run_cfg(1, 2, 1, "R8", "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule